// File: doc/BRIEF.md
# Two-wire serial EEPROM slave controller

This block is the bus-facing slave logic of a small serial EEPROM that holds 512 bytes, split into two 256-byte blocks. It oversamples the two bus lines on the system clock. It recognises Start and Stop conditions, takes in the control byte, checks the device-type code and records which block is addressed. It then runs the word-address, write-data and read-data phases. The slave answers on the data line only through an open-drain enable: when `sda_oe_o` is high, the pad pulls SDA low.

Bytes written in a burst go into a small circular buffer. When the bus master ends a write with a Stop, a programming cycle begins. This cycle is modelled by a fixed-length busy counter. During it, the buffered bytes are copied into the internal byte array, and the slave does not answer the bus at all. Reads return bytes from the array, starting at the current address. The address advances by one for every byte the master acknowledges.

Top module: `twi_ee_slave`

## Requirements
- R1: A falling SDA while SCL is high is a Start. A rising SDA while SCL is high is a Stop. A Start in any state, including a repeated Start in the middle of a transfer, returns the slave to control-byte reception.
- R2: The control byte is taken MSB first. The slave acknowledges it only if bits 7:4 equal 4'b1010. On any other code, `sda_oe_o` stays low and the slave ignores every following byte until the next Start.
- R3: Control bit 1 selects the 256-byte block and becomes bit 8 of the 9-bit internal address. Control bits 3:2 have no effect. Control bit 0 set means read, clear means write.
- R4: For every byte the slave receives while addressed, it raises `sda_oe_o` after SCL falls following the eighth bit. It releases the line after the ninth SCL pulse. The slave asserts `sda_oe_o` only while SCL is low.
- R5: In a write, the byte after the control byte is the low 8 bits of the word address. Any number of data bytes may follow. Only the last eight are kept, with the oldest dropped first. They are stored in arrival order at consecutive addresses starting from the word address, wrapping modulo 512.
- R6: A Stop that ends a write with at least one data byte raises `busy_o` for PROG_CYCLES clocks. A Stop after only a word address starts no programming cycle.
- R7: While `busy_o` is high, `sda_oe_o` stays low: the control byte gets no acknowledge.
- R8: A read sends array bytes MSB first, each bit driven after SCL falls. It starts at {block bit, low 8 bits of the last word address}. On a master acknowledge, the 9-bit address increments, wrapping modulo 512. On a master NACK, the slave releases SDA and stays silent until the next Start or Stop.
- R9: After reset, `sda_oe_o` and `busy_o` are low, the slave waits for a Start, and all array bytes read as 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND level) |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge or a 0 data bit) |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
On every cycle, the assertions check four things: the slave is silent during programming, in the idle state and in the ignoring state; it only starts pulling SDA while SCL is low; a programming cycle starts only after a Stop and never on top of one already running; and a full buffer stays full when it overflows. Other behaviours show only in the bench's scenarios, where the results are compared against a behavioural byte-array model. These are which bytes survive a long burst, the addresses they land at (including the carry into the second block and the wrap at 511), the block and don't-care bits of the control byte, the busy length, and the release of SDA after a master NACK.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0]  DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } twi_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;

endpackage

// File: rtl/twi_bus_mon.sv
module twi_bus_mon
  import twi_ee_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output logic     scl_o,
  output logic     sda_o,
  output bus_evt_t evt_o
);

  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic                   scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sh[TOP];
      sda_q  <= sda_sh[TOP];
    end
  end

  assign scl_o = scl_sh[TOP];
  assign sda_o = sda_sh[TOP];

  always_comb begin
    evt_o.rise  = scl_sh[TOP] & ~scl_q;
    evt_o.fall  = ~scl_sh[TOP] & scl_q;
    evt_o.start = scl_sh[TOP] & scl_q & sda_q & ~sda_sh[TOP];
    evt_o.stop  = scl_sh[TOP] & scl_q & ~sda_q & sda_sh[TOP];
  end

endmodule

// File: rtl/twi_wr_fifo.sv
module twi_wr_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear_i,
  input  logic                           push_i,
  input  logic [DATA_W-1:0]              data_i,
  input  logic [$clog2(DEPTH)-1:0]       rd_idx_i,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic [$clog2(DEPTH+1)-1:0]     count_o
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [AW-1:0]     wptr_q;
  logic [CW-1:0]     count_q;
  logic              full;
  logic [AW-1:0]     oldest;

  assign full   = (count_q == CW'(DEPTH));
  assign oldest = full ? wptr_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      count_q <= '0;
    end else if (clear_i) begin
      wptr_q  <= '0;
      count_q <= '0;
    end else if (push_i) begin
      wptr_q <= wptr_q + AW'(1);
      if (!full) count_q <= count_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !clear_i) slot_q[wptr_q] <= data_i;
  end

  assign rd_data_o = slot_q[oldest + rd_idx_i];
  assign count_o   = count_q;

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_i && !clear_i) |=> (count_o == CW'(DEPTH)));

endmodule

// File: rtl/twi_ee_store.sv
module twi_ee_store #(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BUF_DEPTH   = 8,
  parameter int unsigned PROG_CYCLES = 200
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            go_i,
  input  logic [ADDR_W-1:0]               base_i,
  input  logic [$clog2(BUF_DEPTH+1)-1:0]  cnt_i,
  output logic [$clog2(BUF_DEPTH)-1:0]    buf_idx_o,
  input  logic [DATA_W-1:0]               buf_data_i,
  output logic                            busy_o,
  input  logic [ADDR_W-1:0]               raddr_i,
  output logic [DATA_W-1:0]               rdata_o
);

  localparam int unsigned WORDS = 1 << ADDR_W;
  localparam int unsigned AW    = $clog2(BUF_DEPTH);
  localparam int unsigned CW    = $clog2(BUF_DEPTH + 1);
  localparam int unsigned PW    = $clog2(PROG_CYCLES + 1);

  logic [DATA_W-1:0] cell_q [WORDS];
  logic [PW-1:0]     busy_cnt_q;
  logic [CW-1:0]     idx_q, n_q;
  logic [ADDR_W-1:0] base_q;
  logic              we;
  logic [ADDR_W-1:0] waddr;

  assign busy_o    = (busy_cnt_q != '0);
  assign we        = busy_o && (idx_q < n_q);
  assign waddr     = base_q + ADDR_W'(idx_q);
  assign buf_idx_o = idx_q[AW-1:0];
  assign rdata_o   = cell_q[raddr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt_q <= '0;
      idx_q      <= '0;
      n_q        <= '0;
      base_q     <= '0;
    end else if (go_i && !busy_o) begin
      busy_cnt_q <= PW'(PROG_CYCLES);
      idx_q      <= '0;
      n_q        <= cnt_i;
      base_q     <= base_i;
    end else if (busy_o) begin
      busy_cnt_q <= busy_cnt_q - PW'(1);
      if (we) idx_q <= idx_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WORDS); i++) cell_q[i] <= '0;
    end else if (we) begin
      cell_q[waddr] <= buf_data_i;
    end
  end

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_o);

endmodule

// File: rtl/twi_ee_slave.sv
module twi_ee_slave
  import twi_ee_pkg::*;
#(
  parameter int unsigned BUF_DEPTH   = 8,
  parameter int unsigned PROG_CYCLES = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic busy_o
);

  localparam int unsigned ADDR_W = BYTE_W + 1;
  localparam int unsigned AW     = $clog2(BUF_DEPTH);
  localparam int unsigned CW     = $clog2(BUF_DEPTH + 1);

  bus_evt_t          evt;
  logic              scl_s, sda_s;
  twi_state_e        state_q;
  logic [3:0]        bitcnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              oe_q;
  logic              blk_q;
  logic [ADDR_W-1:0] addr_q;
  logic              byte_done;
  logic              fifo_clear, fifo_push, prog_go;
  logic [AW-1:0]     buf_idx;
  logic [BYTE_W-1:0] buf_data, rdata;
  logic [CW-1:0]     buf_cnt;

  twi_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .evt_o(evt)
  );

  assign byte_done  = evt.fall && (bitcnt_q == 4'd8) &&
                      (state_q == ST_CTRL || state_q == ST_ADDR || state_q == ST_WDATA);
  assign fifo_clear = byte_done && (state_q == ST_ADDR);
  assign fifo_push  = byte_done && (state_q == ST_WDATA);
  assign prog_go    = evt.stop && (state_q == ST_WDATA) && (buf_cnt != '0);

  twi_wr_fifo #(.DEPTH(BUF_DEPTH), .DATA_W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear_i(fifo_clear), .push_i(fifo_push),
    .data_i(shreg_q), .rd_idx_i(buf_idx), .rd_data_o(buf_data), .count_o(buf_cnt)
  );

  twi_ee_store #(
    .ADDR_W(ADDR_W), .DATA_W(BYTE_W), .BUF_DEPTH(BUF_DEPTH), .PROG_CYCLES(PROG_CYCLES)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .go_i(prog_go), .base_i(addr_q), .cnt_i(buf_cnt),
    .buf_idx_o(buf_idx), .buf_data_i(buf_data), .busy_o(busy_o),
    .raddr_i(addr_q), .rdata_o(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      oe_q     <= 1'b0;
      blk_q    <= 1'b0;
      addr_q   <= '0;
    end else if (evt.start) begin
      state_q  <= ST_CTRL;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else if (evt.stop) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else if (state_q != ST_IDLE && state_q != ST_IGNORE) begin
      if (evt.rise) begin
        if (bitcnt_q == 4'd8) begin
          bitcnt_q <= '0;
          // master acknowledge slot of a read: only when the slave is not driving
          if (state_q == ST_RDATA && !oe_q) begin
            if (sda_s) state_q <= ST_IGNORE;
            else       addr_q  <= addr_q + ADDR_W'(1);
          end
        end else begin
          shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
          bitcnt_q <= bitcnt_q + 4'd1;
        end
      end else if (evt.fall) begin
        if (state_q == ST_RDATA) begin
          oe_q <= (bitcnt_q < 4'd8) ? ~rdata[3'd7 - bitcnt_q[2:0]] : 1'b0;
        end else if (bitcnt_q == 4'd8) begin
          unique case (state_q)
            ST_CTRL: begin
              if (busy_o || shreg_q[7:4] != DEV_CODE) begin
                state_q <= ST_IGNORE;
                oe_q    <= 1'b0;
              end else begin
                oe_q  <= 1'b1;
                blk_q <= shreg_q[1];
                if (shreg_q[0]) begin
                  state_q <= ST_RDATA;
                  addr_q  <= {shreg_q[1], addr_q[BYTE_W-1:0]};
                end else begin
                  state_q <= ST_ADDR;
                end
              end
            end
            ST_ADDR: begin
              oe_q    <= 1'b1;
              addr_q  <= {blk_q, shreg_q};
              state_q <= ST_WDATA;
            end
            default: oe_q <= 1'b1;
          endcase
        end else begin
          oe_q <= 1'b0;
        end
      end
    end
  end

  assign sda_oe_o = oe_q;

  // R7
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);

  // R4
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_s);

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !sda_oe_o);

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  // R6
  prog_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(evt.stop));

endmodule

// File: tb/twi_ee_slave_tb_top.sv
module twi_ee_slave_tb_top;

  localparam int PROG = 600;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] mdl [512];

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  twi_ee_slave #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R7: compared on every clock against the rule that programming is silent
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (busy && sda_oe) begin
        errors++;
        $display("FAIL R7 oe during busy actual=1 expected=0");
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; q();
    scl_m = 1'b1; q(); q();
    scl_m = 1'b0; q();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    b = sda_line; q();
    scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(~mack);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  // write burst; model keeps the last eight bytes, oldest dropped, from the word address
  task automatic wr_burst(input logic [7:0] ctrl, input logic [7:0] a, input logic [7:0] data[$]);
    logic ack;
    int   kept, first;
    logic [8:0] base;
    bus_start();
    send_byte(ctrl, ack);
    chk(ack == 1'b1, "R2 control ack", ack, 1);
    send_byte(a, ack);
    chk(ack == 1'b1, "R4 address ack", ack, 1);
    foreach (data[i]) begin
      send_byte(data[i], ack);
      chk(ack == 1'b1, "R4 data ack", ack, 1);
    end
    bus_stop();
    kept  = (data.size() > 8) ? 8 : data.size();
    first = data.size() - kept;
    base  = {ctrl[1], a};
    for (int i = 0; i < kept; i++) mdl[9'(base + 9'(i))] = data[first + i];
  endtask

  task automatic rd_seq(input logic [7:0] ctrl, input logic [7:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    logic [8:0] base;
    bus_start();
    send_byte(ctrl & 8'hFE, ack);
    send_byte(a, ack);
    bus_start();
    send_byte(ctrl | 8'h01, ack);
    chk(ack == 1'b1, "R1 repeated start read ack", ack, 1);
    base = {ctrl[1], a};
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(d === mdl[9'(base + 9'(i))], tag, d, mdl[9'(base + 9'(i))]);
    end
  endtask

  initial begin
    logic ack, b;
    logic [7:0] d;
    logic [7:0] bytes[$];
    int n;

    for (int i = 0; i < 512; i++) mdl[i] = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    q();

    // R9 reset state
    chk(sda_oe == 1'b0, "R9 reset oe", sda_oe, 0);
    chk(busy == 1'b0, "R9 reset busy", busy, 0);
    rd_seq(8'hA0, 8'h33, 1, "R9 reset array reads zero");
    bus_stop();

    // R5 R6 plain write, busy length
    bytes = '{8'h11, 8'h22, 8'h33};
    wr_burst(8'hA0, 8'h10, bytes);
    chk(busy == 1'b1, "R6 busy after write stop", busy, 1);
    n = 0;
    while (busy && n < 2000) begin
      @(posedge clk); #1;
      n++;
    end
    chk(n > PROG - 40 && n <= PROG, "R6 busy length", n, PROG);
    rd_seq(8'hA0, 8'h10, 3, "R5 R8 readback block0");
    bus_stop();

    // R7 no acknowledge while programming
    bytes = '{8'h44};
    wr_burst(8'hA0, 8'h20, bytes);
    bus_start();
    send_byte(8'hA0, ack);
    chk(ack == 1'b0, "R7 control nack while busy", ack, 0);
    bus_stop();
    wait_idle();

    // R2 wrong device code ignored until next Start
    bus_start();
    send_byte(8'hB0, ack);
    chk(ack == 1'b0, "R2 bad code nack", ack, 0);
    send_byte(8'h20, ack);
    chk(ack == 1'b0, "R2 following byte ignored", ack, 0);
    bus_stop();
    q();
    chk(busy == 1'b0, "R2 ignored write no programming", busy, 0);

    // R6 address-only write starts no cycle
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h20, ack);
    bus_stop();
    chk(busy == 1'b0, "R6 no data no busy", busy, 0);
    rd_seq(8'hA0, 8'h20, 1, "R6 data kept after address-only write");
    bus_stop();

    // R3 block select, B2/B1 don't care
    bytes = '{8'h5A};
    wr_burst(8'hAE, 8'h10, bytes);
    wait_idle();
    rd_seq(8'hAB, 8'h10, 1, "R3 block1 read with other don't-care bits");
    bus_stop();
    rd_seq(8'hA0, 8'h10, 1, "R3 block0 untouched");
    bus_stop();

    // R5 overflow keeps last eight
    bytes = {};
    for (int i = 0; i < 11; i++) bytes.push_back(8'hC0 + 8'(i));
    wr_burst(8'hA0, 8'h40, bytes);
    wait_idle();
    rd_seq(8'hA0, 8'h40, 9, "R5 overflow last eight");
    bus_stop();

    // R5 R8 carry into block1 and wrap at 511
    bytes = '{8'h71, 8'h72, 8'h73};
    wr_burst(8'hA0, 8'hFE, bytes);
    wait_idle();
    rd_seq(8'hA0, 8'hFE, 3, "R8 sequential read crosses block");
    bus_stop();
    bytes = '{8'h81, 8'h82};
    wr_burst(8'hA2, 8'hFF, bytes);
    wait_idle();
    rd_seq(8'hA2, 8'hFF, 2, "R5 R8 wrap 511 to 0");

    // R8 after master NACK the line stays released
    bit_in(b);
    chk(b == 1'b1, "R8 released after nack", b, 1);
    chk(sda_oe == 1'b0, "R8 oe low after nack", sda_oe, 0);
    bus_stop();

    // R1 stop returns to idle: bus idle keeps line released
    q();
    chk(sda_line == 1'b1, "R1 idle line high", sda_line, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule